// File: doc/BRIEF.md
# Special Bus Cycle Decoder

This block sits on the system side of a processor bus. It watches every address strobe and picks out the special cycles that the processor issues to report internal conditions. A special cycle has the memory/IO line low, the data/code line low and the write/read line high. The active-low byte enables then carry a code that names the condition; they do not select bytes.

For each special cycle the block raises one single-clock event pulse for that code. The events are shutdown, cache flush, halt and a fourth kind called "other". It also drives the active-low ready for one clock so that the processor can end the cycle, even though no data moves. A byte-enable code outside the four known ones raises an "unknown" pulse, and the cycle is still acknowledged, so the bus never hangs. During a special cycle the address lines must be all zero; a nonzero address raises a protocol-error pulse. Ordinary memory and IO cycles produce no ready and no events from this block.

Top module: `special_cycle_decoder`

## Requirements
- R1: After reset is released, and while it is held, ready_n is high and all six pulse outputs are low.
- R2: A special cycle is recognised only on a rising clock edge where ads_n is low, mem_io is 0, data_code is 0 and write_read is 1. Any other combination, or ads_n high, gives no ready and no pulse.
- R3: A special cycle with be_n (bit 3 down to bit 0) equal to 4'b1110 raises evt_shutdown for exactly one clock, in the clock after the strobe.
- R4: A special cycle with be_n equal to 4'b1101 raises evt_flush for exactly one clock, in the clock after the strobe.
- R5: A special cycle with be_n equal to 4'b1011 raises evt_halt for exactly one clock, in the clock after the strobe.
- R6: A special cycle with be_n equal to 4'b0111 raises evt_other for exactly one clock, in the clock after the strobe.
- R7: A special cycle with any other be_n value raises evt_unknown for one clock and is still acknowledged with ready.
- R8: Every special cycle drives ready_n low for exactly one clock, the clock after the strobe. Special cycles on consecutive clocks each get their own ready clock.
- R9: During a special cycle, a nonzero value on addr raises proto_err in the same clock as ready. An all-zero address raises no error.
- R10: At most one of evt_shutdown, evt_flush, evt_halt, evt_other and evt_unknown is high in any clock, and any of them being high implies ready_n is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads_n | input | 1 | Address strobe, active low |
| mem_io | input | 1 | Cycle definition: 1 memory, 0 IO |
| data_code | input | 1 | Cycle definition: 1 data, 0 code |
| write_read | input | 1 | Cycle definition: 1 write, 0 read |
| be_n | input | 4 | Byte enables, active low; carry the special-cycle code |
| addr | input | ADDR_W | Word address lines |
| ready_n | output | 1 | Cycle acknowledge, active low |
| evt_shutdown | output | 1 | One-clock shutdown event |
| evt_flush | output | 1 | One-clock cache flush event |
| evt_halt | output | 1 | One-clock halt event |
| evt_other | output | 1 | One-clock event for the fourth special code |
| evt_unknown | output | 1 | One-clock event for an unrecognised special code |
| proto_err | output | 1 | One-clock flag: nonzero address in a special cycle |

## Verification
The hardest case to reach from the ports is a special cycle that starts in the very clock in which the previous one is being acknowledged. There, two decodes overlap and a wrong design could merge, stretch or drop a pulse. The bench holds the strobe low on two consecutive clocks with different codes and checks each clock's ready and event separately. It also sends special definitions with the strobe high, as well as the near-miss definitions that differ from a special cycle in one line. This shows that only the full combination triggers an acknowledge.

// File: rtl/special_cycle_decoder.sv
module special_cycle_decoder #(
  parameter int ADDR_W = 30,
  parameter int BE_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ads_n,
  input  logic              mem_io,
  input  logic              data_code,
  input  logic              write_read,
  input  logic [BE_W-1:0]   be_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              ready_n,
  output logic              evt_shutdown,
  output logic              evt_flush,
  output logic              evt_halt,
  output logic              evt_other,
  output logic              evt_unknown,
  output logic              proto_err
);

  localparam logic [BE_W-1:0] CODE_SHUTDOWN = ~(BE_W'(1) << 0);
  localparam logic [BE_W-1:0] CODE_FLUSH    = ~(BE_W'(1) << 1);
  localparam logic [BE_W-1:0] CODE_HALT     = ~(BE_W'(1) << 2);
  localparam logic [BE_W-1:0] CODE_OTHER    = ~(BE_W'(1) << 3);

  logic special;
  logic is_sd, is_fl, is_ha, is_ot, is_unk;

  assign special = ~ads_n & ~mem_io & ~data_code & write_read;
  assign is_sd   = be_n == CODE_SHUTDOWN;
  assign is_fl   = be_n == CODE_FLUSH;
  assign is_ha   = be_n == CODE_HALT;
  assign is_ot   = be_n == CODE_OTHER;
  assign is_unk  = ~(is_sd | is_fl | is_ha | is_ot);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_n      <= 1'b1;
      evt_shutdown <= 1'b0;
      evt_flush    <= 1'b0;
      evt_halt     <= 1'b0;
      evt_other    <= 1'b0;
      evt_unknown  <= 1'b0;
      proto_err    <= 1'b0;
    end else begin
      ready_n      <= ~special;
      evt_shutdown <= special & is_sd;
      evt_flush    <= special & is_fl;
      evt_halt     <= special & is_ha;
      evt_other    <= special & is_ot;
      evt_unknown  <= special & is_unk;
      proto_err    <= special & (|addr);
    end
  end

endmodule

module special_cycle_decoder_chk #(
  parameter int ADDR_W = 30,
  parameter int BE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ads_n,
  input logic              mem_io,
  input logic              data_code,
  input logic              write_read,
  input logic [BE_W-1:0]   be_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ready_n,
  input logic              evt_shutdown,
  input logic              evt_flush,
  input logic              evt_halt,
  input logic              evt_other,
  input logic              evt_unknown,
  input logic              proto_err
);

  logic spc;
  assign spc = !ads_n && !mem_io && !data_code && write_read;

  a_r8_ready_follows_special: assert property (@(posedge clk) disable iff (!rst_n)
    spc |=> !ready_n);

  a_r2_no_ready_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
    !spc |=> ready_n);

  a_r3_shutdown_code: assert property (@(posedge clk) disable iff (!rst_n)
    (spc && be_n == 4'b1110) |=> evt_shutdown);

  a_r4_flush_code: assert property (@(posedge clk) disable iff (!rst_n)
    (spc && be_n == 4'b1101) |=> evt_flush);

  a_r5_halt_code: assert property (@(posedge clk) disable iff (!rst_n)
    (spc && be_n == 4'b1011) |=> evt_halt);

  a_r6_other_code: assert property (@(posedge clk) disable iff (!rst_n)
    (spc && be_n == 4'b0111) |=> evt_other);

  a_r9_addr_error: assert property (@(posedge clk) disable iff (!rst_n)
    (spc && addr != '0) |=> proto_err);

  a_r10_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_shutdown, evt_flush, evt_halt, evt_other, evt_unknown}));

  a_r10_event_has_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_shutdown || evt_flush || evt_halt || evt_other || evt_unknown || proto_err) |-> !ready_n);

endmodule

bind special_cycle_decoder special_cycle_decoder_chk #(.ADDR_W(ADDR_W), .BE_W(BE_W)) chk_i (.*);

// File: tb/special_cycle_decoder_tb_top.sv
module special_cycle_decoder_tb_top;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ads_n = 1'b1;
  logic          mem_io = 1'b1;
  logic          data_code = 1'b1;
  logic          write_read = 1'b0;
  logic [3:0]    be_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic          ready_n, evt_shutdown, evt_flush, evt_halt, evt_other, evt_unknown, proto_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  special_cycle_decoder #(.ADDR_W(AW), .BE_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .ads_n(ads_n), .mem_io(mem_io), .data_code(data_code),
    .write_read(write_read), .be_n(be_n), .addr(addr), .ready_n(ready_n),
    .evt_shutdown(evt_shutdown), .evt_flush(evt_flush), .evt_halt(evt_halt),
    .evt_other(evt_other), .evt_unknown(evt_unknown), .proto_err(proto_err));

  localparam logic [6:0] QUIET = 7'b1_00000_0;

  function automatic logic [6:0] outs();
    return {ready_n, evt_shutdown, evt_flush, evt_halt, evt_other, evt_unknown, proto_err};
  endfunction

  // expected {ready_n, sd, fl, ha, ot, unk, perr} from the requirements
  function automatic logic [6:0] model(logic s_n, logic m, logic d, logic w,
                                       logic [3:0] be, logic [AW-1:0] a);
    logic sp;
    logic [4:0] ev;
    sp = !s_n && !m && !d && w;
    if (!sp) return QUIET;
    case (be)
      4'b1110: ev = 5'b10000;
      4'b1101: ev = 5'b01000;
      4'b1011: ev = 5'b00100;
      4'b0111: ev = 5'b00010;
      default: ev = 5'b00001;
    endcase
    return {1'b0, ev, a != '0};
  endfunction

  task automatic check(string req, logic [6:0] act, logic [6:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(logic s_n, logic m, logic d, logic w, logic [3:0] be, logic [AW-1:0] a);
    ads_n = s_n; mem_io = m; data_code = d; write_read = w; be_n = be; addr = a;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, 1'b0, 4'hF, '0);
  endtask

  // one cycle, checked in the clock after the strobe, then checked quiet again
  task automatic one_cycle(string req, logic s_n, logic m, logic d, logic w,
                           logic [3:0] be, logic [AW-1:0] a);
    @(negedge clk);
    drive(s_n, m, d, w, be, a);
    @(negedge clk);
    idle();
    check(req, outs(), model(s_n, m, d, w, be, a));
    @(negedge clk);
    check({req, " pulse width R8"}, outs(), QUIET);
  endtask

  task automatic t_reset();
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 4'b1110, '0);
    @(negedge clk);
    check("R1 held in reset", outs(), QUIET);
    idle();
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", outs(), QUIET);
  endtask

  task automatic t_known_codes();
    one_cycle("R3 shutdown", 1'b0, 1'b0, 1'b0, 1'b1, 4'b1110, '0);
    one_cycle("R4 flush",    1'b0, 1'b0, 1'b0, 1'b1, 4'b1101, '0);
    one_cycle("R5 halt",     1'b0, 1'b0, 1'b0, 1'b1, 4'b1011, '0);
    one_cycle("R6 other",    1'b0, 1'b0, 1'b0, 1'b1, 4'b0111, '0);
  endtask

  task automatic t_unknown_codes();
    logic [3:0] pats [4] = '{4'b1111, 4'b0000, 4'b1100, 4'b0110};
    foreach (pats[i]) one_cycle("R7 unknown code", 1'b0, 1'b0, 1'b0, 1'b1, pats[i], '0);
  endtask

  task automatic t_ordinary();
    for (int k = 0; k < 8; k++) begin
      if (k == 1) continue; // m=0,d=0,w=1 is the special definition
      one_cycle("R2 ordinary cycle", 1'b0, k[2], k[1], k[0], 4'b1110, '0);
    end
    one_cycle("R2 strobe high", 1'b1, 1'b0, 1'b0, 1'b1, 4'b1101, '0);
  endtask

  task automatic t_addr_err();
    one_cycle("R9 nonzero addr", 1'b0, 1'b0, 1'b0, 1'b1, 4'b1011, AW'(1) << (AW-1));
    one_cycle("R9 low addr bit", 1'b0, 1'b0, 1'b0, 1'b1, 4'b0000, AW'(1));
    one_cycle("R9 ordinary with addr", 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, AW'(5));
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 4'b1110, '0);
    @(negedge clk);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 4'b1011, AW'(3));
    check("R8 first of pair", outs(), 7'b0_10000_0);
    @(negedge clk);
    idle();
    check("R8 second of pair", outs(), 7'b0_00100_1);
    @(negedge clk);
    check("R8 pair ends", outs(), QUIET);
  endtask

  initial begin
    t_reset();
    t_known_codes();
    t_unknown_codes();
    t_ordinary();
    t_addr_err();
    t_back_to_back();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        errors++;
        vectors++;
        $display("FAIL watchdog: run incomplete, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule